// File: doc/BRIEF.md
# Latched-Address One-of-Eight Decoder

This block turns a three-bit binary address into eight select lines, exactly one of which is asserted while the block is enabled. An address hold input sits ahead of the decode. With hold low the address flows straight through, and the block acts as a plain one-of-eight decoder. With hold high the block keeps the address it captured last, so later changes on the address pins leave the outputs alone.

Two enables gate every output after the address stage. One is active high and one is active low, and both must be in their active state for any line to be asserted. Tying one enable active and feeding a serial bit into the other turns the block into a demultiplexer that steers that bit to the addressed line. Wiring an extra address bit into the active-high enable of one instance and the active-low enable of another builds a one-of-sixteen decoder from two parts.

The build-time parameter `ACTIVE_LOW` picks the output sense. With 0 the selected line is 1 and the rest are 0. With 1 the selected line is 0 and the rest are 1. The hold stage is synchronous: a register samples the address on every rising clock edge while hold is low. While hold is low the decode also uses the live address directly, so the path stays transparent within the cycle.

Top module: `addr_latch_decoder`

## Requirements
- R1: During reset and after its release, the held address is 0. If hold is high and both enables are active, output line 0 is asserted.
- R2: While hold is low and both enables are active, the asserted line index equals the address value within the same cycle. sel_i[0] is the least significant bit, so the index is sel_i[2]*4 + sel_i[1]*2 + sel_i[0].
- R3: While hold is high, the outputs follow the address sampled at the last rising clock edge at which hold was low, and changes on sel_i have no effect. The address must be stable at that edge.
- R4: When en_hi_i is 0, all eight outputs are at their deasserted level.
- R5: When en_lo_n_i is 1, all eight outputs are at their deasserted level.
- R6: When en_hi_i is 1 and en_lo_n_i is 0, exactly one output is at its asserted level.
- R7: With ACTIVE_LOW = 0 the asserted level is 1 and the deasserted level is 0. With ACTIVE_LOW = 1 the asserted level is 0 and the deasserted level is 1.
- R8: With one enable held active and a data bit on the other, the addressed output follows the data bit, and every other output stays deasserted.
- R9: The enables act after the hold stage. Toggling an enable while hold is high changes the outputs but does not change the held address.
- R10: Two instances form a one-of-sixteen decoder when a fourth address bit drives en_lo_n_i of the lower instance and en_hi_i of the upper instance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the address hold register |
| rst_n | input | 1 | Asynchronous active-low reset; sets the held address to 0 |
| sel_i | input | SEL_W (3) | Binary address; bit 0 is the least significant |
| hold_i | input | 1 | 1 = keep the captured address, 0 = pass the address through |
| en_hi_i | input | 1 | Active-high output enable |
| en_lo_n_i | input | 1 | Active-low output enable |
| out_o | output | 2**SEL_W (8) | Select lines; sense set by ACTIVE_LOW |

## Verification
The hardest case to reach from the ports is a held address that must survive address changes and enable toggles at the same time. A decoder that only ever decoded live addresses would look correct on most vectors. The vector table first settles an address with hold low across a clock edge. It then raises hold, moves sel_i to other values, and drops each enable in turn, so the later rows show the stale held index rather than the live pins. The cascade sequence repeats this for all sixteen combined addresses, scrambling the low address bits while hold is high.

// File: rtl/addr_decode_pkg.sv
`timescale 1ns/1ps
package addr_decode_pkg;

  // True when both output enables are in their active state.
  function automatic logic enables_on(input logic en_hi, input logic en_lo_n);
    return en_hi & ~en_lo_n;
  endfunction

  // Address seen by the decode: held copy while holding, live pins otherwise.
  function automatic logic [7:0] pick_addr(input logic hold, input logic [7:0] held,
                                           input logic [7:0] live);
    return hold ? held : live;
  endfunction

endpackage

// File: rtl/addr_hold.sv
`timescale 1ns/1ps
module addr_hold #(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic [SEL_W-1:0] held_o,
  output logic [SEL_W-1:0] eff_o
);
  import addr_decode_pkg::*;

  logic [SEL_W-1:0] held_q;
  logic [7:0]       pick;

  // Capture on every edge while transparent; freeze while holding.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       held_q <= '0;
    else if (!hold_i) held_q <= sel_i;
  end

  assign pick   = pick_addr(hold_i, 8'(held_q), 8'(sel_i));
  assign eff_o  = pick[SEL_W-1:0];
  assign held_o = held_q;
endmodule

// File: rtl/onehot_dec.sv
`timescale 1ns/1ps
module onehot_dec #(
  parameter int SEL_W = 3,
  parameter int N_OUT = 1 << SEL_W
) (
  input  logic [SEL_W-1:0] addr_i,
  output logic [N_OUT-1:0] hit_o
);
  for (genvar g = 0; g < N_OUT; g++) begin : g_line
    assign hit_o[g] = (addr_i == SEL_W'(g));
  end
endmodule

// File: rtl/out_gate.sv
`timescale 1ns/1ps
module out_gate #(
  parameter int N_OUT      = 8,
  parameter bit ACTIVE_LOW = 1'b0
) (
  input  logic [N_OUT-1:0] hit_i,
  input  logic             en_ok_i,
  output logic [N_OUT-1:0] asserted_o,
  output logic [N_OUT-1:0] out_o
);
  assign asserted_o = en_ok_i ? hit_i : '0;

  if (ACTIVE_LOW) begin : g_low
    assign out_o = ~asserted_o;
  end else begin : g_high
    assign out_o = asserted_o;
  end
endmodule

// File: rtl/addr_latch_decoder.sv
`timescale 1ns/1ps
module addr_latch_decoder #(
  parameter int SEL_W      = 3,
  parameter bit ACTIVE_LOW = 1'b0,
  localparam int N_OUT     = 1 << SEL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             hold_i,
  input  logic             en_hi_i,
  input  logic             en_lo_n_i,
  output logic [N_OUT-1:0] out_o
);
  import addr_decode_pkg::*;

  // Named internal events, visible to the bound checker.
  logic [SEL_W-1:0] held_addr;
  logic [SEL_W-1:0] eff_addr;
  logic [N_OUT-1:0] hit_vec;
  logic [N_OUT-1:0] asserted_vec;
  logic             en_ok;

  assign en_ok = enables_on(en_hi_i, en_lo_n_i);

  addr_hold #(.SEL_W(SEL_W)) u_hold (
    .clk    (clk),
    .rst_n  (rst_n),
    .hold_i (hold_i),
    .sel_i  (sel_i),
    .held_o (held_addr),
    .eff_o  (eff_addr)
  );

  onehot_dec #(.SEL_W(SEL_W), .N_OUT(N_OUT)) u_dec (
    .addr_i (eff_addr),
    .hit_o  (hit_vec)
  );

  out_gate #(.N_OUT(N_OUT), .ACTIVE_LOW(ACTIVE_LOW)) u_gate (
    .hit_i      (hit_vec),
    .en_ok_i    (en_ok),
    .asserted_o (asserted_vec),
    .out_o      (out_o)
  );
endmodule

// File: rtl/addr_latch_decoder_chk.sv
`timescale 1ns/1ps
module addr_latch_decoder_chk #(
  parameter int SEL_W      = 3,
  parameter bit ACTIVE_LOW = 1'b0,
  localparam int N_OUT     = 1 << SEL_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic [SEL_W-1:0] sel_i,
  input logic             hold_i,
  input logic             en_hi_i,
  input logic             en_lo_n_i,
  input logic [N_OUT-1:0] out_o,
  input logic [SEL_W-1:0] held_addr
);
  logic [N_OUT-1:0] lvl;
  logic             act;
  assign lvl = ACTIVE_LOW ? ~out_o : out_o;
  assign act = en_hi_i && !en_lo_n_i;

  p_one_hot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    act |-> $countones(lvl) == 1);

  p_hi_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !en_hi_i |-> lvl == '0);

  p_lo_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    en_lo_n_i |-> lvl == '0);

  p_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_i && act) |-> lvl == (N_OUT'(1) << sel_i));

  p_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_i && !$past(hold_i) && act) |-> lvl == (N_OUT'(1) << $past(sel_i)));

  p_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_i && $past(hold_i) && act && $past(act)) |-> $stable(out_o));

  p_held_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    hold_i |=> held_addr == $past(held_addr));
endmodule

bind addr_latch_decoder addr_latch_decoder_chk #(.SEL_W(SEL_W), .ACTIVE_LOW(ACTIVE_LOW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sel_i     (sel_i),
  .hold_i    (hold_i),
  .en_hi_i   (en_hi_i),
  .en_lo_n_i (en_lo_n_i),
  .out_o     (out_o),
  .held_addr (held_addr)
);

// File: tb/addr_latch_decoder_bench.sv
`timescale 1ns/1ps
module addr_latch_decoder_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  // Main instance, active-high outputs.
  logic [2:0] sel = 3'd0;
  logic hold = 1'b1, en_hi = 1'b1, en_lo_n = 1'b0;
  logic [7:0] out;

  addr_latch_decoder #(.SEL_W(3), .ACTIVE_LOW(1'b0)) u_addr_latch_decoder (
    .clk(clk), .rst_n(rst_n), .sel_i(sel), .hold_i(hold),
    .en_hi_i(en_hi), .en_lo_n_i(en_lo_n), .out_o(out));

  // Cascade pair, active-low outputs: bit 3 picks the instance.
  logic [2:0] c_sel = 3'd0;
  logic c_hold = 1'b0, c_bit3 = 1'b0;
  logic [7:0] c_lo, c_hi;
  logic [15:0] c_out;
  assign c_out = {c_hi, c_lo};

  addr_latch_decoder #(.SEL_W(3), .ACTIVE_LOW(1'b1)) u_casc_lo (
    .clk(clk), .rst_n(rst_n), .sel_i(c_sel), .hold_i(c_hold),
    .en_hi_i(1'b1), .en_lo_n_i(c_bit3), .out_o(c_lo));
  addr_latch_decoder #(.SEL_W(3), .ACTIVE_LOW(1'b1)) u_casc_hi (
    .clk(clk), .rst_n(rst_n), .sel_i(c_sel), .hold_i(c_hold),
    .en_hi_i(c_bit3), .en_lo_n_i(1'b0), .out_o(c_hi));

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  // {hold, en_hi, en_lo_n, sel[2:0], expected[7:0]}; one row per cycle.
  localparam logic [13:0] VEC [14] = '{
    {3'b010, 3'd0, 8'h01},  // R2
    {3'b010, 3'd5, 8'h20},  // R2
    {3'b010, 3'd7, 8'h80},  // R2
    {3'b010, 3'd3, 8'h08},  // R2, captured at next edge
    {3'b110, 3'd6, 8'h08},  // R3 held 3
    {3'b110, 3'd1, 8'h08},  // R3
    {3'b100, 3'd2, 8'h00},  // R4
    {3'b111, 3'd2, 8'h00},  // R5
    {3'b110, 3'd4, 8'h08},  // R9 held 3 survives enable toggles
    {3'b010, 3'd4, 8'h10},  // R2
    {3'b110, 3'd0, 8'h10},  // R3 held 4
    {3'b001, 3'd6, 8'h00},  // R4/R5
    {3'b010, 3'd6, 8'h40},  // R2
    {3'b110, 3'd2, 8'h40}   // R3 held 6
  };

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    // R1: reset state with hold high.
    repeat (3) @(negedge clk);
    sel = 3'd6;
    #1 check("R1 in reset", {8'h0, out}, 16'h0001);
    @(negedge clk) rst_n = 1'b1;
    repeat (2) @(negedge clk);
    #1 check("R1 after reset", {8'h0, out}, 16'h0001);

    // Vector table.
    for (int i = 0; i < 14; i++) begin
      @(negedge clk);
      {hold, en_hi, en_lo_n, sel} = VEC[i][13:8];
      #1 check($sformatf("R2/R3/R4/R5/R9 row %0d", i), {8'h0, out}, {8'h0, VEC[i][7:0]});
    end

    // R2/R6: every address, transparent.
    for (int a = 0; a < 8; a++) begin
      @(negedge clk);
      {hold, en_hi, en_lo_n} = 3'b010;
      sel = 3'(a);
      #1 check("R2 R6 sweep", {8'h0, out}, 16'(1) << a);
    end

    // R8: demultiplex a serial bit onto held address 5 via en_hi.
    @(negedge clk) sel = 3'd5;
    @(negedge clk) hold = 1'b1;
    for (int b = 0; b < 8; b++) begin
      logic bitv;
      bitv = 1'(8'b1011_0010 >> b);
      @(negedge clk);
      en_hi = bitv;
      sel = 3'(b);
      #1 check("R8 demux", {8'h0, out}, bitv ? 16'h0020 : 16'h0000);
    end
    @(negedge clk) begin hold = 1'b0; en_hi = 1'b1; end

    // R7/R10: cascade, every 16-bit address, live then held with scrambled low bits.
    for (int a = 0; a < 16; a++) begin
      @(negedge clk);
      c_hold = 1'b0;
      c_sel  = 3'(a);
      c_bit3 = a[3];
      #1 check("R7 R10 live", c_out, ~(16'(1) << a));
      @(negedge clk);
      c_hold = 1'b1;
      c_sel  = ~3'(a);
      #1 check("R10 R3 held", c_out, ~(16'(1) << a));
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule